// File: doc/BRIEF.md
# Pipelined TEA Electronic-Codebook Engine

This block is a fully unrolled 64-bit block cipher datapath built on the Tiny Encryption Algorithm. It accepts a plaintext block together with its own 128-bit key on any clock cycle. Every intermediate half-block and every key copy is registered at every stage, so a new block can follow the previous one with no gap. A single parameter selects the encrypt build or the decrypt build. Blocks are handled in electronic-codebook fashion: each result depends only on the block and key that entered with it.

There is no handshake. A one-bit flag travels through a shift register whose depth equals the cipher latency, beside the datapath. The bit leaving the tail tells the consumer whether the block now at the output is a real result or the leftover of a dummy input. A synchronous active-low reset empties that flag register and touches no data register.

Top module: `tea_ecb_pipe`

## Requirements
- R1: A valid block is accepted on every clock cycle, including back-to-back cycles. Its result appears on `out_block` exactly 2*CYCLES rising edges after the edge that captured it, where CYCLES is 32 by default, giving 64.
- R2: With DECRYPT=0 the output is the Tiny Encryption Algorithm encryption of the input, using 32 cycles, delta 32'h9E3779B9 and modulo-2^32 arithmetic. The half-words are packed as v0=`in_block[63:32]` and v1=`in_block[31:0]`. The key words are packed as k0=`in_key[127:96]`, k1=`in_key[95:64]`, k2=`in_key[63:32]` and k3=`in_key[31:0]`.
- R3: With DECRYPT=1 the block inverts R2: applied to an R2 ciphertext under the same key, it returns the original plaintext, with the same packing and the same latency.
- R4: `out_valid` equals the `in_valid` value sampled 2*CYCLES edges earlier. An output that came from a dummy input (`in_valid`=0) is never flagged valid.
- R5: While `rst_n` is low at a rising edge, the valid register is cleared. No block captured at or before that edge is ever flagged valid, including one presented on the reset edge itself.
- R6: Each block is processed with the key presented on its own input cycle. The key may change on every cycle. Identical block and key pairs give identical results whatever blocks lie between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid register |
| in_valid | input | 1 | 1 marks the current input block as real, 0 as dummy |
| in_block | input | 64 | Input block, v0 in the upper word |
| in_key | input | 128 | Key for this block, k0 in the upper word |
| out_valid | output | 1 | 1 marks `out_block` as a real result |
| out_block | output | 64 | Cipher result |

## Verification
Two things can coincide in one cycle: a new block entering the pipeline while an older block leaves it, and a reset edge arriving while real blocks are in flight, possibly with a real block presented on that same edge. The bench provokes the first with long back-to-back runs and random valid/dummy patterns that use a fresh key every cycle. It provokes the second by pulsing reset in the middle of a burst while `in_valid` stays high. An encrypt instance and a decrypt instance run side by side. Every flagged output is judged against a behavioural cipher model and against the original plaintext, and the valid flag is compared against a history of the inputs that the bench clears when it sees reset.

// File: rtl/tea_pipe_pkg.sv
// Package: shared word type and arithmetic for the pipelined TEA datapath.
// Assumes 32-bit words and modulo-2^32 arithmetic throughout.
package tea_pipe_pkg;

    typedef logic [31:0] word_t;

    localparam word_t TEA_DELTA = 32'h9E3779B9;

    // Mixing term of one half-round, computed on the word that is not updated
    function automatic word_t tea_mix(word_t x, word_t ka, word_t kb, word_t s);
        return ((x << 4) + ka) ^ (x + s) ^ ((x >> 5) + kb);
    endfunction

    // Round sum after 'mult' additions of delta, modulo 2^32
    function automatic word_t tea_sum(int unsigned mult);
        return word_t'(TEA_DELTA * word_t'(mult));
    endfunction

endpackage

// File: rtl/tea_half_stage.sv
// Module: one registered Feistel half-round of TEA.
// What it does: updates one 32-bit half of the block from the other half, two
// key words and a round sum that is fixed by the stage position. The other
// half passes through unchanged. One register stage, with no reset on data.
// Assumes: the caller hands in the key pair that this half-round uses.
module tea_half_stage
    import tea_pipe_pkg::*;
#(
    parameter int unsigned STAGE_IDX = 0,
    parameter int unsigned CYCLES    = 32,
    parameter bit          DECRYPT   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] blk_i,
    input  word_t       key_a,
    input  word_t       key_b,
    output logic [63:0] blk_q
);

    localparam int unsigned ROUND    = STAGE_IDX / 2;
    localparam int unsigned HALF     = STAGE_IDX % 2;
    localparam bit          TOUCH_HI = DECRYPT ? (HALF == 1) : (HALF == 0);
    localparam word_t       SUM      = DECRYPT ? tea_sum(CYCLES - ROUND)
                                               : tea_sum(ROUND + 1);

    word_t src_w;
    word_t dst_w;
    word_t mix_w;
    word_t new_w;

    // Pick which half is read and which is rewritten in this stage
    generate
        if (TOUCH_HI) begin : g_upd_hi
            assign src_w = blk_i[31:0];
            assign dst_w = blk_i[63:32];
        end else begin : g_upd_lo
            assign src_w = blk_i[63:32];
            assign dst_w = blk_i[31:0];
        end
    endgenerate

    // Mixing term of this half-round
    assign mix_w = tea_mix(src_w, key_a, key_b, SUM);

    // Encrypt adds the term and decrypt removes it
    generate
        if (DECRYPT) begin : g_sub
            assign new_w = dst_w - mix_w;
        end else begin : g_add
            assign new_w = dst_w + mix_w;
        end
    endgenerate

    // Register the updated block every cycle, with no enable and no reset
    always_ff @(posedge clk) begin
        blk_q <= TOUCH_HI ? {new_w, src_w} : {src_w, new_w};
    end

    // R2: the half that is only read must reach the next stage unchanged
    a_r2_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((TOUCH_HI ? blk_q[31:0] : blk_q[63:32]) == $past(src_w)));

endmodule

// File: rtl/tea_valid_track.sv
// Module: one-bit valid shift register that runs beside the cipher pipeline.
// What it does: inserts the input valid bit at the head each cycle and shows
// the tail bit as the output flag. A synchronous active-low reset empties it.
// Assumes: DEPTH equals the datapath latency and is at least 2.
module tea_valid_track #(
    parameter int unsigned DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] vld_q;

    // Shift the flags by one place per cycle, or clear them all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[DEPTH-2:0], vin};
        end
    end

    // The oldest flag marks the block now at the cipher output
    assign vout = vld_q[DEPTH-1];

    // R5: a reset edge leaves no flag set in the register
    a_r5_reset_flush: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    // R4: a shift adds at most one set flag per cycle
    a_r4_one_per_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(vld_q) <= $past($countones(vld_q)) + 1));

endmodule

// File: rtl/tea_ecb_pipe.sv
// Module: top of the fully pipelined TEA electronic-codebook engine.
// What it does: chains 2*CYCLES half-round stages. The key is carried in a
// register next to each stage, so every block keeps its own key, and the
// valid flag travels with the data at the same latency.
// Assumes: no back-pressure. The consumer takes out_block whenever out_valid is 1.
module tea_ecb_pipe
    import tea_pipe_pkg::*;
#(
    parameter int unsigned CYCLES  = 32,
    parameter bit          DECRYPT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [63:0]  in_block,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [63:0]  out_block
);

    localparam int unsigned STAGES = 2 * CYCLES;
    localparam int unsigned WARM_W = $clog2(STAGES + 1);

    logic [63:0]  blk_s [0:STAGES];
    logic [127:0] key_s [0:STAGES-1];

    assign blk_s[0] = in_block;
    assign key_s[0] = in_key;

    // One half-round per stage, with the key pair chosen by the stage position
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            localparam bit HI = DECRYPT ? ((s % 2) == 1) : ((s % 2) == 0);
            word_t ka;
            word_t kb;

            assign ka = HI ? key_s[s][127:96] : key_s[s][63:32];
            assign kb = HI ? key_s[s][95:64]  : key_s[s][31:0];

            tea_half_stage #(
                .STAGE_IDX (s),
                .CYCLES    (CYCLES),
                .DECRYPT   (DECRYPT)
            ) u_half (
                .clk   (clk),
                .rst_n (rst_n),
                .blk_i (blk_s[s]),
                .key_a (ka),
                .key_b (kb),
                .blk_q (blk_s[s+1])
            );
        end

        for (genvar s = 0; s < STAGES - 1; s++) begin : g_key
            // Carry the full key one stage further along with its block
            always_ff @(posedge clk) begin
                key_s[s+1] <= key_s[s];
            end

            // R6: the key seen by a stage is the one its block entered with
            a_r6_key_carried: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (key_s[s+1] == $past(key_s[s])));
        end
    endgenerate

    assign out_block = blk_s[STAGES];

    // Valid flags run at the same latency as the data
    tea_valid_track #(
        .DEPTH (STAGES)
    ) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .vout  (out_valid)
    );

    // Counter of cycles since reset, used only to bound the valid flag
    logic [WARM_W-1:0] warm_q;

    // Count cycles since reset and stop at the pipeline depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != WARM_W'(STAGES)) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    // R1/R5: no result can be flagged before a full latency has passed since reset
    a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q < WARM_W'(STAGES)) |-> !out_valid);

endmodule

// File: tb/tea_ecb_pipe_bench.sv
`timescale 1ns/1ps
// Bench: an encrypt instance and a decrypt instance share the key and the
// valid stream. The decrypt instance is fed the model ciphertext.
module tea_ecb_pipe_bench;

    localparam int LAT = 64;
    localparam int HD  = 128;
    localparam int GOT = 1024;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [63:0]  in_block;
    logic [63:0]  dec_in_block;
    logic [127:0] in_key;
    logic         out_valid;
    logic [63:0]  out_block;
    logic         dec_valid;
    logic [63:0]  dec_block;

    int errors = 0;
    int checks = 0;
    int enc_seen = 0;
    int ecount = 0;
    logic        hv  [HD];
    logic [63:0] hpt [HD];
    logic [63:0] hct [HD];
    logic [63:0] got [GOT];

    always #10 clk = ~clk;

    tea_ecb_pipe #(.CYCLES(32), .DECRYPT(1'b0)) u_tea_ecb_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
        .in_key(in_key), .out_valid(out_valid), .out_block(out_block));

    tea_ecb_pipe #(.CYCLES(32), .DECRYPT(1'b1)) u_tea_ecb_pipe_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(dec_in_block),
        .in_key(in_key), .out_valid(dec_valid), .out_block(dec_block));

    // Behavioural encryption model
    function automatic logic [63:0] m_enc(logic [63:0] b, logic [127:0] k);
        logic [31:0] v0 = b[63:32];
        logic [31:0] v1 = b[31:0];
        logic [31:0] sm = 32'h0;
        for (int i = 0; i < 32; i++) begin
            sm = sm + 32'h9E3779B9;
            v0 = v0 + (((v1 << 4) + k[127:96]) ^ (v1 + sm) ^ ((v1 >> 5) + k[95:64]));
            v1 = v1 + (((v0 << 4) + k[63:32]) ^ (v0 + sm) ^ ((v0 >> 5) + k[31:0]));
        end
        return {v0, v1};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Record what each edge captured; a reset edge invalidates all of it
    initial for (int i = 0; i < HD; i++) hv[i] = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HD; i++) hv[i] <= 1'b0;
        end else begin
            hv[ecount % HD]  <= in_valid;
            hpt[ecount % HD] <= in_block;
            hct[ecount % HD] <= dec_in_block;
        end
        ecount <= ecount + 1;
    end

    // Compare the outputs at every falling edge against the input history
    always @(negedge clk) begin
        if (ecount > 0) begin
            int  idx;
            logic ev;
            idx = ecount - LAT;
            ev  = (idx >= 0) ? hv[idx % HD] : 1'b0;
            check(out_valid == ev, "R4 enc valid flag", 64'(out_valid), 64'(ev));
            check(dec_valid == ev, "R4 dec valid flag", 64'(dec_valid), 64'(ev));
            if (ev && out_valid) begin
                check(out_block == hct[idx % HD], "R2 ciphertext", out_block, hct[idx % HD]);
                check(dec_block == hpt[idx % HD], "R3 decrypt round trip", dec_block, hpt[idx % HD]);
                if (enc_seen < GOT) got[enc_seen] = out_block;
                enc_seen++;
            end
        end
    end

    task automatic drive(input bit v, input logic [63:0] pt, input logic [127:0] k);
        in_valid     = v;
        in_block     = pt;
        in_key       = k;
        dec_in_block = m_enc(pt, k);
        @(negedge clk);
    endtask

    function automatic logic [127:0] rkey();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [63:0] rblk();
        return {$urandom, $urandom};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, rblk(), rkey());
    endtask

    // R5: reset state with valid input held high
    task automatic t_reset_state();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, rblk(), rkey());
            check(!out_valid && !dec_valid, "R5 reset state", 64'(out_valid), 64'd0);
        end
        rst_n = 1'b1;
    endtask

    // R1/R6: back-to-back real blocks with a new key on every cycle
    task automatic t_back_to_back();
        int base = enc_seen;
        for (int i = 0; i < 80; i++) drive(1'b1, rblk(), rkey());
        idle(LAT + 4);
        check(enc_seen - base == 80, "R1 back-to-back count",
              64'(enc_seen - base), 64'd80);
    endtask

    // R4: random valid/dummy mix
    task automatic t_gaps();
        int base = enc_seen;
        int sent = 0;
        for (int i = 0; i < 300; i++) begin
            bit v = $urandom_range(0, 1) == 1;
            sent += v ? 1 : 0;
            drive(v, rblk(), rkey());
        end
        idle(LAT + 4);
        check(enc_seen - base == sent, "R4 dummy blocks never flagged",
              64'(enc_seen - base), 64'(sent));
    endtask

    // R6: the same pair twice with a different block between gives the same result
    task automatic t_ecb_repeat();
        int base = enc_seen;
        logic [63:0]  a = rblk();
        logic [127:0] k = rkey();
        drive(1'b1, a, k);
        drive(1'b1, rblk(), rkey());
        drive(1'b0, rblk(), rkey());
        drive(1'b1, a, k);
        idle(LAT + 4);
        check(enc_seen - base == 3, "R6 repeat count", 64'(enc_seen - base), 64'd3);
        check(got[base] == got[base+2], "R6 identical pair result", got[base+2], got[base]);
        check(got[base] == m_enc(a, k), "R6 repeat value", got[base], m_enc(a, k));
    endtask

    // R5: reset pulse with blocks in flight and a real block on the reset edge
    task automatic t_flush_mid();
        int base = enc_seen;
        for (int i = 0; i < 20; i++) drive(1'b1, rblk(), rkey());
        idle(30);
        rst_n = 1'b0;
        drive(1'b1, rblk(), rkey());
        rst_n = 1'b1;
        idle(LAT + 10);
        check(enc_seen == base, "R5 flushed blocks stay unflagged",
              64'(enc_seen - base), 64'd0);
        for (int i = 0; i < 5; i++) drive(1'b1, rblk(), rkey());
        idle(LAT + 4);
        check(enc_seen - base == 5, "R5 traffic resumes after flush",
              64'(enc_seen - base), 64'd5);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_block = '0;
        in_key = '0;
        dec_in_block = '0;
        @(negedge clk);
        t_reset_state();
        t_back_to_back();
        t_gaps();
        t_ecb_repeat();
        t_flush_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule